// File: doc/BRIEF.md
# Protected Address Translation Cache

This block translates 32-bit virtual addresses into 28-bit physical addresses for a processor that sits in front of a physically addressed cache. It keeps a small, fully associative set of recent page translations. Each entry records a 20-bit virtual page tag and a 16-bit physical frame, plus four state bits: valid, write permitted, dirty and referenced. The 12-bit page offset passes through unchanged. A request that matches no valid entry raises a miss exception, so a software handler can fetch the translation and install it. A write to a page without write permission raises a protection exception, and the write is not completed.

Installing and invalidating entries is reserved for supervisor mode. A fill goes into the slot that a rotating pointer names, unless an entry with the same tag is already present; in that case the fill overwrites that entry. Every completed access marks its entry as referenced, and a completed write also marks it as dirty. A separate input clears every referenced mark in one cycle, which lets an operating system sample page usage. Each response also reports the dirty and referenced bits the entry held before the access.

Top module: `tlb_xlate`

## Requirements
- R1: On a completed access the physical address is `{frame[15:0], vaddr[11:0]}`, where the frame comes from the entry whose tag equals `vaddr[31:12]`.
- R2: A request whose page matches no valid entry pulses `rsp_miss_exc`, with `rsp_hit` low and `rsp_paddr` zero.
- R3: A write (`req_write`=1) that hits an entry without write permission pulses `rsp_prot_exc`, with `rsp_hit` low, and leaves that entry's dirty bit unchanged.
- R4: A completed write sets its entry's dirty bit. `rsp_dirty` reports the dirty bit as it was before the access.
- R5: Every completed access, read or write, sets its entry's referenced bit, which `rsp_ref` reports as it was before the access. A high `clr_ref` clears all referenced bits in one cycle.
- R6: The responses are registered. They appear in the cycle after the clock edge that samples `req_valid`, last exactly one cycle for each request, and at most one of `rsp_hit`, `rsp_miss_exc` and `rsp_prot_exc` is high.
- R7: A fill whose tag is not present writes a valid entry, with dirty and referenced bits clear, into the slot named by a rotating pointer. The pointer then moves to the next slot and wraps after the last one. After 16 new fills, the next new fill evicts the oldest of them.
- R8: A fill whose tag matches a valid entry overwrites that entry and does not move the pointer.
- R9: `fill_en` and `flush` have no effect while `sup_mode` is low.
- R10: A flush in supervisor mode invalidates every entry, so later requests miss.
- R11: After reset every entry is invalid and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| sup_mode | input | 1 | Supervisor mode; enables fill and flush |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | 20 | Virtual page tag to install |
| fill_ppn | input | 16 | Physical frame to install |
| fill_wr_ok | input | 1 | Write permission of the installed entry |
| flush | input | 1 | Invalidate all entries |
| clr_ref | input | 1 | Clear all referenced bits |
| rsp_hit | output | 1 | Access completed |
| rsp_paddr | output | 28 | Physical address, zero unless `rsp_hit` |
| rsp_miss_exc | output | 1 | Miss exception |
| rsp_prot_exc | output | 1 | Write protection exception |
| rsp_dirty | output | 1 | Dirty bit of the hit entry before the access |
| rsp_ref | output | 1 | Referenced bit of the hit entry before the access |

## Verification
The hardest case to reach from the ports is the rotating victim choice, because the pointer is not visible. The stimulus flushes the buffer, installs sixteen distinct pages and then installs one more. It then checks that only the first of the sixteen now misses. Next it refills a page that is already present, which must not move the pointer, and installs another new page. That page must evict the slot of the refilled page and not its neighbour. The dirty and referenced bits are made visible by reading a page twice: the second response shows what the first one left behind.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 28;
  localparam int PG_OFF_W = 12;
  localparam int VPN_W    = VA_W - PG_OFF_W;
  localparam int PPN_W    = PA_W - PG_OFF_W;

  typedef struct packed {
    logic             valid;
    logic             dirty;
    logic             refd;
    logic             wr_ok;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  tlb_entry_t [ENTRIES-1:0] tab,
  input  logic [VPN_W-1:0]         vpn,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tab[g].valid && (tab[g].vpn == vpn);
  end

  // tags are unique among valid entries, so at most one bit is set
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      if (ptr == IDX_W'(ENTRIES - 1)) ptr <= '0;
      else                            ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        sup_mode,
  input  logic        fill_en,
  input  logic [19:0] fill_vpn,
  input  logic [15:0] fill_ppn,
  input  logic        fill_wr_ok,
  input  logic        flush,
  input  logic        clr_ref,
  output logic        rsp_hit,
  output logic [27:0] rsp_paddr,
  output logic        rsp_miss_exc,
  output logic        rsp_prot_exc,
  output logic        rsp_dirty,
  output logic        rsp_ref
);
  tlb_entry_t [ENTRIES-1:0] tab;

  logic             look_hit, fill_hit;
  logic [IDX_W-1:0] look_idx, fill_hit_idx, rr_ptr, fill_idx;
  tlb_entry_t       ent;
  logic             prot_now, ok_now, miss_now, fill_go, flush_go;

  tlb_match #(.ENTRIES(ENTRIES)) u_look (
    .tab (tab),
    .vpn (req_vaddr[VA_W-1:PG_OFF_W]),
    .hit (look_hit),
    .idx (look_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_fmatch (
    .tab (tab),
    .vpn (fill_vpn),
    .hit (fill_hit),
    .idx (fill_hit_idx)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk (clk),
    .rst (rst),
    .adv (fill_go && !fill_hit),
    .ptr (rr_ptr)
  );

  always_comb begin
    ent      = tab[look_idx];
    prot_now = req_valid && look_hit && req_write && !ent.wr_ok;
    ok_now   = req_valid && look_hit && !prot_now;
    miss_now = req_valid && !look_hit;
    fill_go  = sup_mode && fill_en;
    flush_go = sup_mode && flush;
    fill_idx = fill_hit ? fill_hit_idx : rr_ptr;
  end

  // registered responses
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      rsp_miss_exc <= 1'b0;
      rsp_prot_exc <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_ref      <= 1'b0;
    end else begin
      rsp_hit      <= ok_now;
      rsp_paddr    <= ok_now ? {ent.ppn, req_vaddr[PG_OFF_W-1:0]} : '0;
      rsp_miss_exc <= miss_now;
      rsp_prot_exc <= prot_now;
      rsp_dirty    <= ok_now && ent.dirty;
      rsp_ref      <= ok_now && ent.refd;
    end
  end

  // entry state: clear-ref, then access marks, then flush, then fill
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        tab[g] <= '0;
      end else begin
        if (clr_ref) tab[g].refd <= 1'b0;
        if (ok_now && look_idx == IDX_W'(g)) begin
          tab[g].refd <= 1'b1;
          if (req_write) tab[g].dirty <= 1'b1;
        end
        if (flush_go) tab[g].valid <= 1'b0;
        if (fill_go && fill_idx == IDX_W'(g)) begin
          tab[g].valid <= 1'b1;
          tab[g].dirty <= 1'b0;
          tab[g].refd  <= 1'b0;
          tab[g].wr_ok <= fill_wr_ok;
          tab[g].vpn   <= fill_vpn;
          tab[g].ppn   <= fill_ppn;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        req_write,
  input logic        rsp_hit,
  input logic [27:0] rsp_paddr,
  input logic        rsp_miss_exc,
  input logic        rsp_prot_exc,
  input logic        rsp_dirty,
  input logic        rsp_ref
);
  // R6
  excl_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_miss_exc, rsp_prot_exc}));

  // R6
  no_req_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_hit || rsp_miss_exc || rsp_prot_exc));

  // R6
  req_gets_resp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_hit || rsp_miss_exc || rsp_prot_exc));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));

  // R3
  prot_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_prot_exc |-> $past(req_write));

  // R2
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss_exc |-> (rsp_paddr == 28'd0 && !rsp_dirty && !rsp_ref));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_write    (req_write),
  .rsp_hit      (rsp_hit),
  .rsp_paddr    (rsp_paddr),
  .rsp_miss_exc (rsp_miss_exc),
  .rsp_prot_exc (rsp_prot_exc),
  .rsp_dirty    (rsp_dirty),
  .rsp_ref      (rsp_ref)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        sup_mode = 1'b0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_ppn = '0;
  logic        fill_wr_ok = 1'b0;
  logic        flush = 1'b0;
  logic        clr_ref = 1'b0;
  logic        rsp_hit, rsp_miss_exc, rsp_prot_exc, rsp_dirty, rsp_ref;
  logic [27:0] rsp_paddr;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic o_hit, o_miss, o_prot, o_dirty, o_ref;
  logic [27:0] o_pa;

  always #2.5 clk = ~clk;

  tlb_xlate u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle request; captures response; then checks the response has ended (R6)
  task automatic access(input logic [31:0] va, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    o_hit = rsp_hit; o_miss = rsp_miss_exc; o_prot = rsp_prot_exc;
    o_pa = rsp_paddr; o_dirty = rsp_dirty; o_ref = rsp_ref;
    @(negedge clk);
    chk(!(rsp_hit || rsp_miss_exc || rsp_prot_exc), "R6 pulse length",
        {29'd0, rsp_hit, rsp_miss_exc, rsp_prot_exc}, 32'd0);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [15:0] ppn, input logic wok, input logic sup);
    @(negedge clk);
    sup_mode = sup; fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wok;
    @(negedge clk);
    fill_en = 1'b0; sup_mode = 1'b0;
  endtask

  task automatic do_flush(input logic sup);
    @(negedge clk);
    sup_mode = sup; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0; sup_mode = 1'b0;
  endtask

  task automatic t_reset();
    chk({rsp_hit, rsp_miss_exc, rsp_prot_exc, rsp_dirty, rsp_ref} == 5'b0 && rsp_paddr == 0,
        "R11 outputs after reset", {27'd0, rsp_hit, rsp_miss_exc, rsp_prot_exc, rsp_dirty, rsp_ref}, 0);
    access(32'hC0001560, 1'b0);
    chk(o_miss && !o_hit, "R11 empty after reset", {30'd0, o_hit, o_miss}, 32'd1);
  endtask

  task automatic t_read_hit();
    fill(20'hC0001, 16'hA200, 1'b1, 1'b1);
    access(32'hC0001560, 1'b0);
    chk(o_hit && o_pa == 28'hA200560, "R1 paddr", {4'd0, o_pa}, 32'h0A200560);
    chk(!o_dirty && !o_ref, "R7 fresh bits clear", {30'd0, o_dirty, o_ref}, 0);
    access(32'hC0001FFF, 1'b0);
    chk(o_pa == 28'hA200FFF && o_ref && !o_dirty, "R5 ref after read", {3'd0, o_ref, o_pa}, 32'h1A200FFF);
  endtask

  task automatic t_miss();
    access(32'hC0002450, 1'b1);
    chk(o_miss && !o_hit && !o_prot && o_pa == 0, "R2 miss",
        {o_pa, 1'b0, o_hit, o_miss, o_prot}, 32'h00000002 << 0);
  endtask

  task automatic t_prot();
    fill(20'hC0003, 16'h8003, 1'b0, 1'b1);
    access(32'hC0003010, 1'b1);
    chk(o_prot && !o_hit && !o_miss, "R3 protection", {29'd0, o_hit, o_miss, o_prot}, 32'd1);
    access(32'hC0003010, 1'b0);
    chk(o_hit && !o_dirty && o_pa == 28'h8003010, "R3 dirty unchanged", {3'd0, o_dirty, o_pa}, 32'h08003010);
  endtask

  task automatic t_dirty();
    fill(20'hC0004, 16'h7290, 1'b1, 1'b1);
    access(32'hC0004ABC, 1'b1);
    chk(o_hit && !o_dirty && !o_ref, "R4 write completes", {29'd0, o_hit, o_dirty, o_ref}, 32'd4);
    access(32'hC0004000, 1'b0);
    chk(o_dirty && o_ref, "R4 dirty set by write", {30'd0, o_dirty, o_ref}, 32'd3);
  endtask

  task automatic t_clr_ref();
    @(negedge clk); clr_ref = 1'b1;
    @(negedge clk); clr_ref = 1'b0;
    access(32'hC0004000, 1'b0);
    chk(!o_ref && o_dirty, "R5 clear ref", {30'd0, o_dirty, o_ref}, 32'd2);
  endtask

  task automatic t_sup_gate();
    fill(20'h12345, 16'h1111, 1'b1, 1'b0);
    access(32'h12345000, 1'b0);
    chk(o_miss, "R9 fill ignored in user mode", {31'd0, o_miss}, 32'd1);
    do_flush(1'b0);
    access(32'hC0001000, 1'b0);
    chk(o_hit, "R9 flush ignored in user mode", {31'd0, o_hit}, 32'd1);
    do_flush(1'b1);
    access(32'hC0001000, 1'b0);
    chk(o_miss && !o_hit, "R10 flush invalidates", {30'd0, o_hit, o_miss}, 32'd1);
    access(32'hC0004000, 1'b0);
    chk(o_miss, "R10 flush all entries", {31'd0, o_miss}, 32'd1);
  endtask

  task automatic t_replace();
    do_flush(1'b1);
    for (int i = 0; i < 16; i++) fill(20'hA0000 + 20'(i), 16'h3000 + 16'(i), 1'b1, 1'b1);
    fill(20'hB0000, 16'h4000, 1'b1, 1'b1);
    access(32'hA0000000, 1'b0);
    chk(o_miss, "R7 oldest evicted", {31'd0, o_miss}, 32'd1);
    access(32'hA0001000, 1'b0);
    chk(o_hit && o_pa == 28'h3001000, "R7 next kept", {4'd0, o_pa}, 32'h03001000);
    access(32'hB0000123, 1'b0);
    chk(o_hit && o_pa == 28'h4000123, "R7 new entry", {4'd0, o_pa}, 32'h04000123);
    fill(20'hA0001, 16'h5555, 1'b1, 1'b1);
    access(32'hA0001008, 1'b0);
    chk(o_hit && o_pa == 28'h5555008, "R8 in-place overwrite", {4'd0, o_pa}, 32'h05555008);
    fill(20'hC0000, 16'h6000, 1'b1, 1'b1);
    access(32'hA0001008, 1'b0);
    chk(o_miss, "R8 pointer not moved (refilled slot evicted)", {31'd0, o_miss}, 32'd1);
    access(32'hA0002000, 1'b0);
    chk(o_hit && o_pa == 28'h3002000, "R8 neighbour kept", {4'd0, o_pa}, 32'h03002000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_miss();
    t_prot();
    t_dirty();
    t_clr_ref();
    t_sup_gate();
    t_replace();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule